// File: doc/BRIEF.md
# Register Status Rename Table

This block holds the architectural floating-point registers together with a pending-producer field for each one. The pending field names the reservation station whose result will become the register's next value, so the table is the live map from architectural register to virtual register. A zero in that field means the stored value is current.

The issue stage uses the block to read two source registers. For each source it gets back either a ready value or the tag of the station that will produce it. In the same cycle the issue stage claims a destination register by writing the issuing station's tag into that register's pending field. Each cycle the result bus is presented as a tag with its data. Every register still waiting on that tag takes the data and becomes ready. A later claim on a register replaces any older tag. The older producer's broadcast then leaves the register alone, which removes write-after-write and write-after-read hazards at issue.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register reads as ready (tag 0) with value 0.
- R2: An issue with `iss_valid` high writes `iss_tag` into the pending field of register `iss_dst`, effective from the next cycle. Source reads in the issue cycle see the state from before the claim.
- R3: A source read returns tag 0 and the stored value when the register's pending field is zero. Otherwise it returns the pending tag, with the value output driven to 0.
- R4: When `bus_valid` is high and `bus_tag` equals a register's pending tag, that register stores `bus_data` and its pending field becomes 0 from the next cycle.
- R5: A broadcast whose tag differs from a register's current pending tag leaves that register's value and tag unchanged. This also covers an older producer whose claim was replaced.
- R6: When an issue claims a register in the same cycle that a broadcast matches its old tag, the register takes the new tag and keeps its previous value.
- R7: A source read whose register's pending tag matches a valid broadcast in the same cycle returns tag 0 and `bus_data`.
- R8: A broadcast with `bus_tag` 0, or with `bus_valid` low, neither writes any register nor bypasses into a source read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue claims the destination register this cycle |
| iss_dst | input | IDX_W (4) | Destination register index |
| iss_tag | input | TAG_W (4) | Tag of the issuing station, nonzero |
| src_a_idx | input | IDX_W (4) | First source register index |
| src_b_idx | input | IDX_W (4) | Second source register index |
| src_a_val | output | DATA_W (32) | First source value, 0 while pending |
| src_a_tag | output | TAG_W (4) | First source producer tag, 0 when ready |
| src_b_val | output | DATA_W (32) | Second source value, 0 while pending |
| src_b_tag | output | TAG_W (4) | Second source producer tag, 0 when ready |
| bus_valid | input | 1 | Result bus carries a result this cycle |
| bus_tag | input | TAG_W (4) | Tag of the station broadcasting |
| bus_data | input | DATA_W (32) | Broadcast result value |

## Verification
The hardest case to reach is a register claimed twice, where the first producer broadcasts after the second claim, and the second claim coincides with a different broadcast. Only a precise ordering of issues and broadcasts across several cycles creates it. The stimulus table builds it step by step: it claims register 2 with one tag and then another, broadcasts the replaced tag, and then issues a third claim in the same cycle that the second tag broadcasts. Each step reads the register back through the source ports, so the same-cycle bypass, the stale broadcast and the claim that wins are all seen at the outputs.

// File: rtl/rst_pkg.sv
package rst_pkg;

  // Single point of configuration for value and tag widths.
  localparam int DATA_W   = 32;
  localparam int TAG_W    = 4;
  localparam int NUM_REGS = 16;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [TAG_W-1:0]  tag_t;

  // Result of one source lookup: producer tag (0 = ready) and value.
  typedef struct packed {
    tag_t  tag;
    data_t val;
  } operand_t;

  // A pending tag is satisfied by a valid, nonzero broadcast of the same tag.
  function automatic logic tag_hit(input tag_t pend, input logic bv, input tag_t bt);
    return bv && (bt != '0) && (pend == bt);
  endfunction

  // Operand as seen at issue: bypass first, then pending, then ready value.
  function automatic operand_t resolve(input data_t val, input tag_t pend,
                                       input logic bv, input tag_t bt, input data_t bd);
    operand_t r;
    if (tag_hit(pend, bv, bt)) begin
      r.tag = '0;
      r.val = bd;
    end else if (pend != '0) begin
      r.tag = pend;
      r.val = '0;
    end else begin
      r.tag = '0;
      r.val = val;
    end
    return r;
  endfunction

endpackage

// File: rtl/rst_entry.sv
module rst_entry
  import rst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  claim_we,
  input  tag_t  claim_tag,
  input  logic  bus_valid,
  input  tag_t  bus_tag,
  input  data_t bus_data,
  output data_t cur_val,
  output tag_t  cur_tag,
  output logic  bus_hit
);

  data_t val_q;
  tag_t  tag_q;

  assign bus_hit = tag_hit(tag_q, bus_valid, bus_tag);
  assign cur_val = val_q;
  assign cur_tag = tag_q;

  // A new claim takes priority: the newest producer owns the register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      tag_q <= '0;
    end else if (claim_we) begin
      tag_q <= claim_tag;
    end else if (bus_hit) begin
      val_q <= bus_data;
      tag_q <= '0;
    end
  end

endmodule

// File: rtl/rst_dst_decode.sv
module rst_dst_decode #(
  parameter int REGS  = 16,
  localparam int IDX_W = $clog2(REGS)
) (
  input  logic             valid,
  input  logic [IDX_W-1:0] dst,
  output logic [REGS-1:0]  we
);

  for (genvar i = 0; i < REGS; i++) begin : g_dec
    assign we[i] = valid && (dst == IDX_W'(i));
  end

endmodule

// File: rtl/rst_read_port.sv
module rst_read_port
  import rst_pkg::*;
#(
  parameter int REGS  = 16,
  localparam int IDX_W = $clog2(REGS)
) (
  input  logic [IDX_W-1:0] sel,
  input  data_t            vals [REGS],
  input  tag_t             tags [REGS],
  input  logic             bus_valid,
  input  tag_t             bus_tag,
  input  data_t            bus_data,
  output data_t            out_val,
  output tag_t             out_tag
);

  operand_t op;

  always_comb begin
    op = resolve(vals[sel], tags[sel], bus_valid, bus_tag, bus_data);
  end

  assign out_val = op.val;
  assign out_tag = op.tag;

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rst_pkg::*;
#(
  parameter int REGS   = rst_pkg::NUM_REGS,
  localparam int IDX_W = $clog2(REGS),
  localparam int DW    = rst_pkg::DATA_W,
  localparam int TW    = rst_pkg::TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [IDX_W-1:0] iss_dst,
  input  logic [TW-1:0]    iss_tag,
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic [IDX_W-1:0] src_b_idx,
  output logic [DW-1:0]    src_a_val,
  output logic [TW-1:0]    src_a_tag,
  output logic [DW-1:0]    src_b_val,
  output logic [TW-1:0]    src_b_tag,
  input  logic             bus_valid,
  input  logic [TW-1:0]    bus_tag,
  input  logic [DW-1:0]    bus_data
);

  // Named internal events, brought out for the checker.
  logic [REGS-1:0] claim_vec;
  logic [REGS-1:0] hit_vec;
  data_t           ent_val [REGS];
  tag_t            ent_tag [REGS];

  rst_dst_decode #(.REGS(REGS)) u_dec (
    .valid (iss_valid),
    .dst   (iss_dst),
    .we    (claim_vec)
  );

  for (genvar i = 0; i < REGS; i++) begin : g_ent
    rst_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .claim_we  (claim_vec[i]),
      .claim_tag (iss_tag),
      .bus_valid (bus_valid),
      .bus_tag   (bus_tag),
      .bus_data  (bus_data),
      .cur_val   (ent_val[i]),
      .cur_tag   (ent_tag[i]),
      .bus_hit   (hit_vec[i])
    );
  end

  rst_read_port #(.REGS(REGS)) u_rd_a (
    .sel       (src_a_idx),
    .vals      (ent_val),
    .tags      (ent_tag),
    .bus_valid (bus_valid),
    .bus_tag   (bus_tag),
    .bus_data  (bus_data),
    .out_val   (src_a_val),
    .out_tag   (src_a_tag)
  );

  rst_read_port #(.REGS(REGS)) u_rd_b (
    .sel       (src_b_idx),
    .vals      (ent_val),
    .tags      (ent_tag),
    .bus_valid (bus_valid),
    .bus_tag   (bus_tag),
    .bus_data  (bus_data),
    .out_val   (src_b_val),
    .out_tag   (src_b_tag)
  );

endmodule

// File: rtl/rename_status_table_chk.sv
module rename_status_table_chk #(
  parameter int REGS   = 16,
  localparam int IDX_W = $clog2(REGS),
  localparam int DW    = rst_pkg::DATA_W,
  localparam int TW    = rst_pkg::TAG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic [IDX_W-1:0] iss_dst,
  input logic [TW-1:0]    iss_tag,
  input logic [IDX_W-1:0] src_a_idx,
  input logic [DW-1:0]    src_a_val,
  input logic [TW-1:0]    src_a_tag,
  input logic             bus_valid,
  input logic [TW-1:0]    bus_tag,
  input logic [DW-1:0]    bus_data,
  input logic [REGS-1:0]  claim_vec,
  input logic [REGS-1:0]  hit_vec,
  input logic [DW-1:0]    ent_val [REGS],
  input logic [TW-1:0]    ent_tag [REGS]
);

  // R2: the claimed register shows the issuing tag one cycle later.
  p_claim_sets_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> ent_tag[$past(iss_dst)] == $past(iss_tag));

  // R3: a pending source reports its producer and a zero value.
  p_pending_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_tag != '0) |-> (src_a_val == '0 && src_a_tag == ent_tag[src_a_idx]));

  // R7: a source waiting on the live broadcast is bypassed.
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_tag != '0 && ent_tag[src_a_idx] == bus_tag)
      |-> (src_a_tag == '0 && src_a_val == bus_data));

  for (genvar i = 0; i < REGS; i++) begin : g_reg
    // R1: reset leaves every entry ready and zero.
    p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (ent_val[i] == '0 && ent_tag[i] == '0));

    // R4: an unclaimed hit captures the bus data and clears the tag.
    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec[i] && !claim_vec[i]) |=> (ent_val[i] == $past(bus_data) && ent_tag[i] == '0));

    // R5: no claim and no hit leaves the entry untouched.
    p_no_hit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!claim_vec[i] && !hit_vec[i]) |=> ($stable(ent_val[i]) && $stable(ent_tag[i])));

    // R6: a claim never changes the stored value, even with a matching broadcast.
    p_claim_keeps_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      claim_vec[i] |=> $stable(ent_val[i]));

    // R8: a blank or idle bus never hits.
    p_blank_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_valid || bus_tag == '0) |-> !hit_vec[i]);
  end

endmodule

bind rename_status_table rename_status_table_chk #(.REGS(REGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_dst   (iss_dst),
  .iss_tag   (iss_tag),
  .src_a_idx (src_a_idx),
  .src_a_val (src_a_val),
  .src_a_tag (src_a_tag),
  .bus_valid (bus_valid),
  .bus_tag   (bus_tag),
  .bus_data  (bus_data),
  .claim_vec (claim_vec),
  .hit_vec   (hit_vec),
  .ent_val   (ent_val),
  .ent_tag   (ent_tag)
);

// File: tb/test_rename_status_table.sv
module test_rename_status_table;

  localparam int LIMIT = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_dst = '0, iss_tag = '0, src_a_idx = '0, src_b_idx = '0;
  logic [31:0] src_a_val, src_b_val;
  logic [3:0]  src_a_tag, src_b_tag;
  logic        bus_valid = 1'b0;
  logic [3:0]  bus_tag = '0;
  logic [31:0] bus_data = '0;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rename_status_table i_rename_status_table (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .src_a_val(src_a_val), .src_a_tag(src_a_tag),
    .src_b_val(src_b_val), .src_b_tag(src_b_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
  );

  typedef struct packed {
    logic        iv;
    logic [3:0]  sa, sb, dst, itag;
    logic        bv;
    logic [3:0]  btag;
    logic [31:0] bdata;
    logic [3:0]  eat;
    logic [31:0] eav;
    logic [3:0]  ebt;
    logic [31:0] ebv;
    logic [3:0]  req;
  } vec_t;

  // Expected source outputs are those seen in the cycle the inputs are applied.
  localparam vec_t VECS [20] = '{
    '{1'b0, 4'd1,  4'd2, 4'd0,  4'd0, 1'b0, 4'd0, 32'h0,    4'd0, 32'h0,    4'd0, 32'h0,    4'd1}, // R1 reset state
    '{1'b1, 4'd1,  4'd1, 4'd1,  4'd3, 1'b0, 4'd0, 32'h0,    4'd0, 32'h0,    4'd0, 32'h0,    4'd2}, // R2 read before claim
    '{1'b0, 4'd1,  4'd2, 4'd0,  4'd0, 1'b0, 4'd0, 32'h0,    4'd3, 32'h0,    4'd0, 32'h0,    4'd3}, // R3 pending
    '{1'b0, 4'd1,  4'd1, 4'd0,  4'd0, 1'b1, 4'd3, 32'hAAAA, 4'd0, 32'hAAAA, 4'd0, 32'hAAAA, 4'd7}, // R7 bypass
    '{1'b1, 4'd1,  4'd2, 4'd2,  4'd5, 1'b0, 4'd0, 32'h0,    4'd0, 32'hAAAA, 4'd0, 32'h0,    4'd4}, // R4 captured
    '{1'b1, 4'd2,  4'd1, 4'd2,  4'd6, 1'b0, 4'd0, 32'h0,    4'd5, 32'h0,    4'd0, 32'hAAAA, 4'd2}, // R2 reclaim
    '{1'b0, 4'd2,  4'd1, 4'd0,  4'd0, 1'b1, 4'd5, 32'h5555, 4'd6, 32'h0,    4'd0, 32'hAAAA, 4'd5}, // R5 stale tag
    '{1'b0, 4'd2,  4'd3, 4'd0,  4'd0, 1'b1, 4'd0, 32'hFFFF, 4'd6, 32'h0,    4'd0, 32'h0,    4'd8}, // R8 tag zero
    '{1'b0, 4'd1,  4'd3, 4'd0,  4'd0, 1'b0, 4'd0, 32'h0,    4'd0, 32'hAAAA, 4'd0, 32'h0,    4'd8}, // R8 nothing written
    '{1'b1, 4'd2,  4'd2, 4'd2,  4'd7, 1'b1, 4'd6, 32'h6666, 4'd0, 32'h6666, 4'd0, 32'h6666, 4'd7}, // R7 bypass on collision
    '{1'b0, 4'd2,  4'd1, 4'd0,  4'd0, 1'b0, 4'd0, 32'h0,    4'd7, 32'h0,    4'd0, 32'hAAAA, 4'd6}, // R6 new tag won
    '{1'b0, 4'd4,  4'd4, 4'd0,  4'd0, 1'b1, 4'd7, 32'h7777, 4'd0, 32'h0,    4'd0, 32'h0,    4'd4}, // R4 broadcast
    '{1'b0, 4'd2,  4'd4, 4'd0,  4'd0, 1'b0, 4'd0, 32'h0,    4'd0, 32'h7777, 4'd0, 32'h0,    4'd4}, // R4 captured
    '{1'b1, 4'd0,  4'd0, 4'd0,  4'd1, 1'b0, 4'd0, 32'h0,    4'd0, 32'h0,    4'd0, 32'h0,    4'd2}, // R2 reg 0
    '{1'b1, 4'd15, 4'd0, 4'd15, 4'd2, 1'b0, 4'd0, 32'h0,    4'd0, 32'h0,    4'd1, 32'h0,    4'd2}, // R2 reg 15
    '{1'b0, 4'd0,  4'd15,4'd0,  4'd0, 1'b0, 4'd0, 32'h0,    4'd1, 32'h0,    4'd2, 32'h0,    4'd3}, // R3 both pending
    '{1'b0, 4'd15, 4'd0, 4'd0,  4'd0, 1'b1, 4'd2, 32'h2222, 4'd0, 32'h2222, 4'd1, 32'h0,    4'd7}, // R7 one port only
    '{1'b0, 4'd15, 4'd0, 4'd0,  4'd0, 1'b0, 4'd0, 32'h0,    4'd0, 32'h2222, 4'd1, 32'h0,    4'd4}, // R4 reg 15
    '{1'b0, 4'd0,  4'd1, 4'd0,  4'd0, 1'b0, 4'd1, 32'h9999, 4'd1, 32'h0,    4'd0, 32'hAAAA, 4'd8}, // R8 idle bus
    '{1'b0, 4'd0,  4'd0, 4'd0,  4'd0, 1'b0, 4'd0, 32'h0,    4'd1, 32'h0,    4'd1, 32'h0,    4'd8}  // R8 no write
  };

  task automatic check(input int req, input string what,
                       input logic [3:0] gt, input logic [3:0] et,
                       input logic [31:0] gv, input logic [31:0] ev);
    n_chk++;
    if (gt !== et || gv !== ev) begin
      n_err++;
      $display("FAIL R%0d %s: got tag=%0d val=%h expected tag=%0d val=%h",
               req, what, gt, gv, et, ev);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got cycle=%0d expected below %0d", cyc, LIMIT);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (VECS[k]) begin
      @(negedge clk);
      iss_valid = VECS[k].iv;
      src_a_idx = VECS[k].sa;
      src_b_idx = VECS[k].sb;
      iss_dst   = VECS[k].dst;
      iss_tag   = VECS[k].itag;
      bus_valid = VECS[k].bv;
      bus_tag   = VECS[k].btag;
      bus_data  = VECS[k].bdata;
      #1;
      check(int'(VECS[k].req), $sformatf("vector %0d port a", k),
            src_a_tag, VECS[k].eat, src_a_val, VECS[k].eav);
      check(int'(VECS[k].req), $sformatf("vector %0d port b", k),
            src_b_tag, VECS[k].ebt, src_b_val, VECS[k].ebv);
    end

    // Directed: reset in the middle of traffic clears values and tags (R1).
    @(negedge clk);
    iss_valid = 1'b1; iss_dst = 4'd5; iss_tag = 4'd9;
    bus_valid = 1'b0; src_a_idx = 4'd1; src_b_idx = 4'd2;
    #1;
    check(1, "before reset reg1", src_a_tag, 4'd0, src_a_val, 32'hAAAA);
    @(negedge clk);
    iss_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    src_a_idx = 4'd5; src_b_idx = 4'd15;
    #1;
    check(1, "after reset reg5", src_a_tag, 4'd0, src_a_val, 32'h0);
    check(1, "after reset reg15", src_b_tag, 4'd0, src_b_val, 32'h0);
    src_a_idx = 4'd1; src_b_idx = 4'd2;
    #1;
    check(1, "after reset reg1", src_a_tag, 4'd0, src_a_val, 32'h0);
    check(1, "after reset reg2", src_b_tag, 4'd0, src_b_val, 32'h0);

    // Directed: a pending source where another register's tag is broadcast is not bypassed (R5).
    @(negedge clk);
    iss_valid = 1'b1; iss_dst = 4'd3; iss_tag = 4'd4;
    @(negedge clk);
    iss_valid = 1'b0; src_a_idx = 4'd3;
    bus_valid = 1'b1; bus_tag = 4'd8; bus_data = 32'h1234;
    #1;
    check(5, "other tag on bus", src_a_tag, 4'd4, src_a_val, 32'h0);
    @(negedge clk);
    bus_valid = 1'b0;
    #1;
    check(5, "other tag not captured", src_a_tag, 4'd4, src_a_val, 32'h0);

    @(negedge clk);
    finish_run();
  end

endmodule